// File: doc/BRIEF.md
# Memory Error Capture and Interrupt Unit

This unit sits next to the ECC checker of a memory controller and turns the checker's per-access verdicts into software-visible error state. For each checked read the checker presents a valid strobe, a corrected-error indication, an uncorrectable-error indication, the 64-bit data word, the check/syndrome value and the access address. The unit keeps two sticky detect flags, holds one snapshot of the failing access, and drives a single interrupt line. Corrected errors do not raise their flag directly. They are counted, and the flag is raised only when a programmable threshold is reached.

Software reaches the unit through a simple 32-bit register port with a word index, a write strobe and a combinational read. Detect flags are cleared by writing ones. The unit also offers a write-path fault injector. When it is armed, the write data and check bits leaving the controller are XORed with programmable masks, so that software can exercise the checker end to end.

Top module: `memerr_report_unit`

## Requirements
- R1: After reset every register reads zero, `irq` is low and the injector passes write data and check bits through unchanged.
- R2: An access with `chk_valid` high and `chk_mbe` high sets the uncorrectable flag (status bit 1 at word 0) on the next clock edge. Indications that arrive while `chk_valid` is low are ignored.
- R3: Each accepted corrected error (`chk_valid` and `chk_sbe`) increments a counter. The threshold is bits 23:16 of word 3 and the count reads back in bits 7:0 of word 3. When the incremented count reaches the threshold, the corrected flag (status bit 0) is set and the count returns to zero. Writing word 3 also resets the count.
- R4: With a threshold of zero, corrected errors neither count nor set the corrected flag.
- R5: Writing word 0 clears each flag whose data bit is one and leaves the other flags alone, so an all-ones write clears both. A flag that is set in the same cycle as the clearing write stays set.
- R6: The snapshot is loaded on a reported event: an uncorrectable error, or a corrected error that reaches the threshold. The registers are data bits 31:0 at word 4, data bits 63:32 at word 5, check value at word 6, address bits 31:0 at word 7, and the upper address bits zero-extended at word 8.
- R7: The snapshot loads only while both flags are clear. Later errors leave it untouched until software clears the flags.
- R8: In wide-bus mode (`narrow_bus_mode` low) only check bits 7:0 are kept and bits 15:8 read zero. In narrow-bus mode all 16 bits are kept.
- R9: `irq` is high exactly while some flag is set whose enable is set in word 1 (bit 0 for corrected, bit 1 for uncorrectable).
- R10: Word 2 bit 0 suppresses detection and counting of corrected errors, and bit 1 suppresses detection of uncorrectable errors. Zero enables both.
- R11: Words 9 and 10 hold XOR masks for write data bits 31:0 and 63:32. Word 11 bits 7:0 hold the check-bit mask and bit 8 arms injection. The masks apply only while bit 8 is set.
- R12: An access that signals both corrected and uncorrectable errors is treated as uncorrectable only: the counter does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| chk_valid | input | 1 | Checker verdict valid for this cycle |
| chk_sbe | input | 1 | Checker saw a corrected (single-bit) error |
| chk_mbe | input | 1 | Checker saw an uncorrectable error |
| chk_data | input | 64 | Data word of the checked access |
| chk_syn | input | 16 | Check/syndrome value of the checked access |
| chk_addr | input | 40 | Address of the checked access |
| narrow_bus_mode | input | 1 | High selects 32-bit bus mode (keep 16 check bits) |
| wr_data_in | input | 64 | Write data toward memory, before injection |
| wr_chk_in | input | 8 | Write check bits, before injection |
| wr_data_out | output | 64 | Write data after injection |
| wr_chk_out | output | 8 | Write check bits after injection |
| irq | output | 1 | Error interrupt |

## Verification
The bench goes after the threshold edges. With a threshold of three it checks that the first two corrected errors stay silent and that the third raises the flag and zeroes the count. A design with an off-by-one compare would fire one error early or late. Thresholds of one and zero are also covered, and a design that mishandled zero would either report on every error or count without bound. The capture freeze is checked with a second error that carries different data, which would overwrite the snapshot in a design that ignored the flags. A clearing write that lands in the same cycle as a new error exposes a design that lets the clear win and so loses the event. Further cases cover simultaneous corrected and uncorrectable indications, bus-mode truncation of the check value, and the disable bits, where a wrong design would still set flags or advance the counter.

// File: rtl/mecu_pkg.sv
package mecu_pkg;
   localparam int REG_IDX_W = 4;
   localparam int DWORD_W   = 32;
   localparam int NFLAG     = 2;
   localparam int FLAG_SBE  = 0;
   localparam int FLAG_MBE  = 1;
   localparam int THR_LSB   = 16;
   localparam int INJ_ARM_BIT = 8;

   typedef enum logic [REG_IDX_W-1:0] {
      REG_STATUS  = 4'd0,
      REG_IRQ_EN  = 4'd1,
      REG_DISABLE = 4'd2,
      REG_SBE_CTL = 4'd3,
      REG_CAP_DLO = 4'd4,
      REG_CAP_DHI = 4'd5,
      REG_CAP_CHK = 4'd6,
      REG_CAP_ALO = 4'd7,
      REG_CAP_AHI = 4'd8,
      REG_INJ_DLO = 4'd9,
      REG_INJ_DHI = 4'd10,
      REG_INJ_CTL = 4'd11
   } reg_idx_e;
endpackage

// File: rtl/mecu_sbe_counter.sv
module mecu_sbe_counter #(
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic [THR_W-1:0] thr_i,
   input  logic             inc_i,
   output logic [THR_W-1:0] cnt_o,
   output logic             hit_o
);
   logic [THR_W-1:0] cnt_q;
   logic [THR_W:0]   cnt_inc;
   logic             thr_live;

   assign thr_live = (thr_i != '0);
   assign cnt_inc  = {1'b0, cnt_q} + {{THR_W{1'b0}}, 1'b1};
   assign hit_o    = inc_i && thr_live && (cnt_inc >= {1'b0, thr_i});
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && thr_live) begin
         cnt_q <= hit_o ? '0 : cnt_inc[THR_W-1:0];
      end
   end

   // R3: the running count never reaches a live threshold
   assert_cnt_below_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_i != '0) |-> (cnt_q < thr_i));

   // R4: a zero threshold freezes the count
   assert_thr_zero_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((thr_i == '0) && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mecu_capture.sv
module mecu_capture #(
   parameter int DATA_W      = 64,
   parameter int ADDR_W      = 40,
   parameter int CHK_W       = 16,
   parameter int WIDE_KEEP   = 8,
   parameter int NARROW_KEEP = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              narrow_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CHK_W-1:0]  syn_i,
   output logic [DATA_W-1:0] data_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CHK_W-1:0]  chk_o
);
   if (!(WIDE_KEEP <= NARROW_KEEP && NARROW_KEEP <= CHK_W && WIDE_KEEP > 0)) begin : g_bad_keep
      $error("mecu_capture: keep widths must satisfy 0 < WIDE_KEEP <= NARROW_KEEP <= CHK_W");
   end

   logic [CHK_W-1:0]  keep;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CHK_W-1:0]  chk_q;

   for (genvar i = 0; i < CHK_W; i++) begin : g_keep
      if (i < WIDE_KEEP) begin : g_always
         assign keep[i] = 1'b1;
      end else if (i < NARROW_KEEP) begin : g_mode
         assign keep[i] = narrow_i;
      end else begin : g_never
         assign keep[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         addr_q <= '0;
         chk_q  <= '0;
      end else if (load_i) begin
         data_q <= data_i;
         addr_q <= addr_i;
         chk_q  <= syn_i & keep;
      end
   end

   assign data_o = data_q;
   assign addr_o = addr_q;
   assign chk_o  = chk_q;

   // R8: wide-bus captures keep only the low check bits
   assert_wide_chk_trunc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !narrow_i) |=> ((chk_q >> WIDE_KEEP) == '0));
endmodule

// File: rtl/mecu_inject.sv
module mecu_inject #(
   parameter int DATA_W  = 64,
   parameter int ECC_W   = 8,
   parameter bit PRESENT = 1'b1
) (
   input  logic              arm_i,
   input  logic [DATA_W-1:0] dmask_i,
   input  logic [ECC_W-1:0]  cmask_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [ECC_W-1:0]  chk_i,
   output logic [DATA_W-1:0] data_o,
   output logic [ECC_W-1:0]  chk_o
);
   if (PRESENT) begin : g_xor
      assign data_o = data_i ^ (arm_i ? dmask_i : '0);
      assign chk_o  = chk_i ^ (arm_i ? cmask_i : '0);
   end else begin : g_pass
      logic unused_inj;
      assign unused_inj = ^{arm_i, dmask_i, cmask_i};
      assign data_o = data_i;
      assign chk_o  = chk_i;
   end
endmodule

// File: rtl/memerr_report_unit.sv
module memerr_report_unit
   import mecu_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int CHK_W      = 16,
   parameter int ECC_W      = 8,
   parameter int THR_W      = 8,
   parameter bit INJECT_EN  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [REG_IDX_W-1:0]  reg_addr,
   input  logic [DWORD_W-1:0]    reg_wdata,
   output logic [DWORD_W-1:0]    reg_rdata,
   input  logic                  chk_valid,
   input  logic                  chk_sbe,
   input  logic                  chk_mbe,
   input  logic [2*DWORD_W-1:0]  chk_data,
   input  logic [CHK_W-1:0]      chk_syn,
   input  logic [ADDR_W-1:0]     chk_addr,
   input  logic                  narrow_bus_mode,
   input  logic [2*DWORD_W-1:0]  wr_data_in,
   input  logic [ECC_W-1:0]      wr_chk_in,
   output logic [2*DWORD_W-1:0]  wr_data_out,
   output logic [ECC_W-1:0]      wr_chk_out,
   output logic                  irq
);
   localparam int DATA_W = 2 * DWORD_W;
   localparam int AHI_W  = ADDR_W - DWORD_W;

   if (ADDR_W <= DWORD_W || ADDR_W > 2 * DWORD_W) begin : g_bad_addr
      $error("memerr_report_unit: ADDR_W must lie in 33..64");
   end
   if (THR_W > 8 || CHK_W > DWORD_W || ECC_W > INJ_ARM_BIT) begin : g_bad_field
      $error("memerr_report_unit: field widths exceed their register slots");
   end

   logic [NFLAG-1:0]   flags_q, irq_en_q, dis_q, set_vec, clr_vec;
   logic [THR_W-1:0]   thr_q, sbe_cnt;
   logic [DWORD_W-1:0] inj_dlo_q, inj_dhi_q;
   logic [ECC_W-1:0]   inj_chk_q;
   logic               inj_arm_q;
   logic               sbe_seen, mbe_seen, sbe_hit, cap_load;
   logic [DATA_W-1:0]  cap_data;
   logic [ADDR_W-1:0]  cap_addr;
   logic [CHK_W-1:0]   cap_chk;

   function automatic logic wr_to(input reg_idx_e idx);
      return reg_wr && (reg_addr == idx);
   endfunction

   // Accepted verdicts: an uncorrectable indication masks a corrected one
   assign mbe_seen = chk_valid && chk_mbe && !dis_q[FLAG_MBE];
   assign sbe_seen = chk_valid && chk_sbe && !chk_mbe && !dis_q[FLAG_SBE];

   mecu_sbe_counter #(.THR_W(THR_W)) sbe_cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (wr_to(REG_SBE_CTL)),
      .thr_i (thr_q),
      .inc_i (sbe_seen),
      .cnt_o (sbe_cnt),
      .hit_o (sbe_hit)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[FLAG_SBE] = sbe_hit;
      set_vec[FLAG_MBE] = mbe_seen;
      clr_vec           = wr_to(REG_STATUS) ? reg_wdata[NFLAG-1:0] : '0;
   end

   assign cap_load = (set_vec != '0) && (flags_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q   <= '0;
         irq_en_q  <= '0;
         dis_q     <= '0;
         thr_q     <= '0;
         inj_dlo_q <= '0;
         inj_dhi_q <= '0;
         inj_chk_q <= '0;
         inj_arm_q <= 1'b0;
      end else begin
         flags_q <= (flags_q & ~clr_vec) | set_vec;
         if (wr_to(REG_IRQ_EN))  irq_en_q  <= reg_wdata[NFLAG-1:0];
         if (wr_to(REG_DISABLE)) dis_q     <= reg_wdata[NFLAG-1:0];
         if (wr_to(REG_SBE_CTL)) thr_q     <= reg_wdata[THR_LSB +: THR_W];
         if (wr_to(REG_INJ_DLO)) inj_dlo_q <= reg_wdata;
         if (wr_to(REG_INJ_DHI)) inj_dhi_q <= reg_wdata;
         if (wr_to(REG_INJ_CTL)) begin
            inj_chk_q <= reg_wdata[ECC_W-1:0];
            inj_arm_q <= reg_wdata[INJ_ARM_BIT];
         end
      end
   end

   mecu_capture #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .CHK_W       (CHK_W),
      .WIDE_KEEP   (ECC_W),
      .NARROW_KEEP (CHK_W)
   ) capture_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (cap_load),
      .narrow_i (narrow_bus_mode),
      .data_i   (chk_data),
      .addr_i   (chk_addr),
      .syn_i    (chk_syn),
      .data_o   (cap_data),
      .addr_o   (cap_addr),
      .chk_o    (cap_chk)
   );

   mecu_inject #(.DATA_W(DATA_W), .ECC_W(ECC_W), .PRESENT(INJECT_EN)) inject_i (
      .arm_i   (inj_arm_q),
      .dmask_i ({inj_dhi_q, inj_dlo_q}),
      .cmask_i (inj_chk_q),
      .data_i  (wr_data_in),
      .chk_i   (wr_chk_in),
      .data_o  (wr_data_out),
      .chk_o   (wr_chk_out)
   );

   assign irq = |(flags_q & irq_en_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_STATUS:  reg_rdata[NFLAG-1:0] = flags_q;
         REG_IRQ_EN:  reg_rdata[NFLAG-1:0] = irq_en_q;
         REG_DISABLE: reg_rdata[NFLAG-1:0] = dis_q;
         REG_SBE_CTL: begin
            reg_rdata[THR_LSB +: THR_W] = thr_q;
            reg_rdata[THR_W-1:0]        = sbe_cnt;
         end
         REG_CAP_DLO: reg_rdata = cap_data[DWORD_W-1:0];
         REG_CAP_DHI: reg_rdata = cap_data[DATA_W-1:DWORD_W];
         REG_CAP_CHK: reg_rdata = DWORD_W'(cap_chk);
         REG_CAP_ALO: reg_rdata = cap_addr[DWORD_W-1:0];
         REG_CAP_AHI: reg_rdata = DWORD_W'(cap_addr[ADDR_W-1:DWORD_W]);
         REG_INJ_DLO: reg_rdata = inj_dlo_q;
         REG_INJ_DHI: reg_rdata = inj_dhi_q;
         REG_INJ_CTL: begin
            reg_rdata[ECC_W-1:0]   = inj_chk_q;
            reg_rdata[INJ_ARM_BIT] = inj_arm_q;
         end
         default:     reg_rdata = '0;
      endcase
   end

   logic unused_ahi;
   assign unused_ahi = (AHI_W > 0);

   // R2: an accepted uncorrectable error is flagged on the next edge
   assert_mbe_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && chk_mbe && !dis_q[FLAG_MBE]) |=> flags_q[FLAG_MBE]);

   // R5: a clearing write without a concurrent event drops the flag
   assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_STATUS && reg_wdata[FLAG_MBE]
       && !(chk_valid && chk_mbe && !dis_q[FLAG_MBE])) |=> !flags_q[FLAG_MBE]);

   // R7: the snapshot is frozen while any flag is pending
   assert_capture_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q != '0) |=> ($stable(cap_data) && $stable(cap_addr) && $stable(cap_chk)));

   // R9: an enabled pending flag always drives the interrupt
   assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[FLAG_SBE] && irq_en_q[FLAG_SBE]) |-> irq);

   // R10: a disabled uncorrectable flag cannot become set
   assert_disable_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q[FLAG_MBE] && !flags_q[FLAG_MBE]) |=> !flags_q[FLAG_MBE]);
endmodule

// File: tb/memerr_report_unit_tb_top.sv
`timescale 1ns/1ps
module memerr_report_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        chk_valid = 1'b0, chk_sbe = 1'b0, chk_mbe = 1'b0;
   logic [63:0] chk_data = '0;
   logic [15:0] chk_syn = '0;
   logic [39:0] chk_addr = '0;
   logic        narrow_bus_mode = 1'b0;
   logic [63:0] wr_data_in = 64'h0123_4567_89AB_CDEF;
   logic [7:0]  wr_chk_in = 8'h5A;
   logic [63:0] wr_data_out;
   logic [7:0]  wr_chk_out;
   logic        irq;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   memerr_report_unit dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chk_valid(chk_valid),
      .chk_sbe(chk_sbe), .chk_mbe(chk_mbe), .chk_data(chk_data), .chk_syn(chk_syn),
      .chk_addr(chk_addr), .narrow_bus_mode(narrow_bus_mode), .wr_data_in(wr_data_in),
      .wr_chk_in(wr_chk_in), .wr_data_out(wr_data_out), .wr_chk_out(wr_chk_out), .irq(irq)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] idx, input logic [31:0] val);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = idx; reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [3:0] idx, input logic [31:0] exp);
      reg_addr = idx;
      #0.5;
      check(tag, {32'h0, reg_rdata}, {32'h0, exp});
   endtask

   task automatic err_event(input bit v, input bit s, input bit m, input logic [63:0] d,
                            input logic [39:0] a, input logic [15:0] syn);
      @(negedge clk);
      chk_valid = v; chk_sbe = s; chk_mbe = m; chk_data = d; chk_addr = a; chk_syn = syn;
      @(negedge clk);
      chk_valid = 1'b0; chk_sbe = 1'b0; chk_mbe = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 12; i++) rd_check("R1 reset reg", 4'(i), 32'h0);
      check("R1 reset irq", {63'h0, irq}, 64'h0);
      check("R1 reset passthrough data", wr_data_out, wr_data_in);
   endtask

   task automatic t_mbe_capture;
      err_event(1, 0, 1, 64'hA5A5_0001_1234_5678, 40'h12_8765_4320, 16'h1234);
      rd_check("R2 mbe flag", 0, 32'h2);
      check("R9 irq masked", {63'h0, irq}, 64'h0);
      rd_check("R6 cap data lo", 4, 32'h1234_5678);
      rd_check("R6 cap data hi", 5, 32'hA5A5_0001);
      rd_check("R8 wide chk", 6, 32'h34);
      rd_check("R6 cap addr lo", 7, 32'h8765_4320);
      rd_check("R6 cap addr hi", 8, 32'h12);
      wr_reg(1, 32'h3);
      check("R9 irq on", {63'h0, irq}, 64'h1);
      err_event(1, 0, 1, 64'hFFFF_0000_DEAD_BEEF, 40'h00_0000_0040, 16'h00AA);
      rd_check("R7 cap held lo", 4, 32'h1234_5678);
      rd_check("R7 cap held addr", 7, 32'h8765_4320);
      wr_reg(0, 32'h1);
      rd_check("R5 zero bit keeps flag", 0, 32'h2);
      wr_reg(0, 32'hFFFF_FFFF);
      rd_check("R5 all ones clears", 0, 32'h0);
      check("R9 irq off", {63'h0, irq}, 64'h0);
   endtask

   task automatic t_sbe_threshold;
      wr_reg(3, 32'h0003_0000);
      rd_check("R3 thr readback", 3, 32'h0003_0000);
      err_event(1, 1, 0, 64'h1, 40'h1, 16'h1);
      err_event(1, 1, 0, 64'h2, 40'h2, 16'h2);
      rd_check("R3 below thr no flag", 0, 32'h0);
      rd_check("R3 count two", 3, 32'h0003_0002);
      narrow_bus_mode = 1'b1;
      err_event(1, 1, 0, 64'h0000_00FF_0000_0001, 40'h00_0000_1000, 16'hBEEF);
      narrow_bus_mode = 1'b0;
      rd_check("R3 thr reached flag", 0, 32'h1);
      rd_check("R3 count restarts", 3, 32'h0003_0000);
      rd_check("R6 cap on hit lo", 4, 32'h1);
      rd_check("R6 cap on hit hi", 5, 32'hFF);
      rd_check("R6 cap addr hi zero", 8, 32'h0);
      rd_check("R8 narrow chk", 6, 32'hBEEF);
      check("R9 irq sbe", {63'h0, irq}, 64'h1);
      err_event(1, 0, 1, 64'h0, 40'h0, 16'h0);
      rd_check("R5 both set", 0, 32'h3);
      wr_reg(0, 32'h2);
      rd_check("R5 clear mbe only", 0, 32'h1);
      wr_reg(0, 32'hFFFF_FFFF);
   endtask

   task automatic t_thr_edges;
      wr_reg(3, 32'h0001_0000);
      err_event(1, 1, 0, 64'h5, 40'h5, 16'h5);
      rd_check("R3 thr one", 0, 32'h1);
      wr_reg(0, 32'h1);
      wr_reg(3, 32'h0);
      for (int i = 0; i < 3; i++) err_event(1, 1, 0, 64'h7, 40'h7, 16'h7);
      rd_check("R4 thr zero no flag", 0, 32'h0);
      rd_check("R4 thr zero no count", 3, 32'h0);
      check("R4 irq stays low", {63'h0, irq}, 64'h0);
   endtask

   task automatic t_disable;
      wr_reg(2, 32'h2);
      err_event(1, 0, 1, 64'h9, 40'h9, 16'h9);
      rd_check("R10 mbe disabled", 0, 32'h0);
      check("R10 irq low", {63'h0, irq}, 64'h0);
      wr_reg(3, 32'h0001_0000);
      wr_reg(2, 32'h1);
      err_event(1, 1, 0, 64'h9, 40'h9, 16'h9);
      rd_check("R10 sbe disabled", 0, 32'h0);
      rd_check("R10 sbe count frozen", 3, 32'h0001_0000);
      wr_reg(2, 32'h0);
      err_event(1, 1, 0, 64'h9, 40'h9, 16'h9);
      rd_check("R10 zero enables", 0, 32'h1);
      wr_reg(0, 32'hFFFF_FFFF);
   endtask

   task automatic t_both_and_valid;
      wr_reg(3, 32'h0002_0000);
      err_event(1, 1, 1, 64'h3, 40'h3, 16'h3);
      rd_check("R12 both is mbe", 0, 32'h2);
      rd_check("R12 count unmoved", 3, 32'h0002_0000);
      wr_reg(0, 32'hFFFF_FFFF);
      err_event(0, 1, 1, 64'h4, 40'h4, 16'h4);
      rd_check("R2 invalid ignored", 0, 32'h0);
      rd_check("R2 invalid no count", 3, 32'h0002_0000);
   endtask

   task automatic t_set_wins;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 0; reg_wdata = 32'hFFFF_FFFF;
      chk_valid = 1'b1; chk_mbe = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; chk_valid = 1'b0; chk_mbe = 1'b0;
      rd_check("R5 set wins over clear", 0, 32'h2);
      wr_reg(0, 32'hFFFF_FFFF);
      rd_check("R5 cleared after", 0, 32'h0);
   endtask

   task automatic t_inject;
      wr_reg(9, 32'h0000_000F);
      wr_reg(10, 32'h8000_0000);
      wr_reg(11, 32'h0000_000C);
      #0.5;
      check("R11 unarmed data", wr_data_out, 64'h0123_4567_89AB_CDEF);
      check("R11 unarmed chk", {56'h0, wr_chk_out}, 64'h5A);
      wr_reg(11, 32'h0000_010C);
      #0.5;
      check("R11 armed data", wr_data_out, 64'h8123_4567_89AB_CDE0);
      check("R11 armed chk", {56'h0, wr_chk_out}, 64'h56);
      rd_check("R11 ctrl readback", 11, 32'h0000_010C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mbe_capture();
      t_sbe_threshold();
      t_thr_edges();
      t_disable();
      t_both_and_valid();
      t_set_wins();
      t_inject();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule